// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block is a clocked controller that performs single write cycles into an asynchronous static RAM. The system side offers an address and a data word under a valid/ready handshake. The block then drives the memory's active-low chip-select and write-strobe, its address lines, and its data lines together with their output enable, so that each of the memory's minimum write timings is met.

Every interval is fixed at elaboration. The parameters give the clock period in nanoseconds and a speed grade. Each nanosecond limit is divided by the period and rounded up to whole clocks, with no phase shorter than one clock. The write window is the overlap of the two low strobes. It opens when write-strobe falls, because chip-select is already low by then. It closes when write-strobe rises, one or more clocks before chip-select rises. Because write-strobe ends the write, the shorter recovery and hold limits are the ones that apply.

Top module: `sram_write_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `mem_ce_n` and `mem_we_n` are 1, and `mem_dq_oe` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. While `req_ready` is 0, or while `req_valid` is 0, `mem_addr` and `mem_dq_o` keep their values and no new cycle starts.
- R3: In the first cycle after acceptance, `mem_ce_n` is 0 and `mem_addr` holds the accepted address. The address stays unchanged until the next acceptance.
- R4: `mem_we_n` falls S cycles after `mem_ce_n` falls and stays low for P cycles. S = max(1, ceil(tAS/T)). P = max(1, ceil(tWP/T), ceil(tDW/T), ceil(tCW/T)−S, ceil(tAW/T)−S). Here T is `CLK_NS`.
- R5: `mem_dq_oe` is 1 exactly while `mem_we_n` is low and during the hold phase that follows. While it is 1, `mem_dq_o` equals the accepted data.
- R6: `mem_we_n` rises first. `mem_ce_n` stays low for H = max(1, ceil(tWR/T), ceil(tDH/T)) cycles after that rise, and then rises on the same edge that drops `mem_dq_oe`.
- R7: `req_ready` returns to 1 in cycle B after acceptance, counting the first cycle as 0. B = max(S+P+H, ceil(tWC/T)).
- R8: `GRADE` selects the limits in ns as follows. Grade 0: tWC=70, tCW=tAW=65, tWP=55, tDW=30. Grade 1: tWC=85, tCW=tAW=75, tWP=65, tDW=35. Grade 2: tWC=120, tCW=tAW=100, tWP=85, tDW=45. All grades use tAS=0, tWR=5, tDH=0. The measured low times of the strobes meet these limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dq_o | output | DATA_W | Memory data lines, outgoing value |
| mem_dq_oe | output | 1 | Drive enable for the data lines |
| mem_ce_n | output | 1 | Memory chip-select, active low |
| mem_we_n | output | 1 | Memory write-strobe, active low |

## Verification
Three instances, one per speed grade, receive the same sweep of address and data words. Each output is compared cycle by cycle against the phase lengths the bench derives from the nanosecond table. An off-by-one in any rounding shows up as a strobe that is one clock short or long, or as `req_ready` returning at the wrong cycle. During some writes the bench keeps `req_valid` high with different values while the block is busy. A design that accepted such a request would change `mem_addr` partway through a cycle. A design that let chip-select rise together with write-strobe, or that drove the data lines before write-strobe fell, would break the expected pattern of `mem_ce_n` and `mem_dq_oe` around the end of the strobe.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_STROBE  = 3'd2,
        PH_HOLD    = 3'd3,
        PH_RECOVER = 3'd4
    } phase_e;

    // Minimum write limits of one speed grade, in ns
    typedef struct packed {
        int unsigned cyc;     // full cycle
        int unsigned sel;     // select low to end of write
        int unsigned adv;     // address valid to end of write
        int unsigned asu;     // address setup
        int unsigned pulse;   // strobe low
        int unsigned rec;     // recovery, strobe-terminated
        int unsigned dsu;     // data valid to end of write
        int unsigned dhd;     // data hold, strobe-terminated
    } limits_ns_t;

    // Phase lengths in clocks
    typedef struct packed {
        int unsigned setup;
        int unsigned strobe;
        int unsigned hold;
        int unsigned recover;
        int unsigned busy;
    } phase_len_t;

    function automatic limits_ns_t grade_limits(input int unsigned grade);
        limits_ns_t l;
        l.asu = 0;
        l.rec = 5;
        l.dhd = 0;
        case (grade)
            1: begin l.cyc = 85;  l.sel = 75;  l.adv = 75;  l.pulse = 65; l.dsu = 35; end
            2: begin l.cyc = 120; l.sel = 100; l.adv = 100; l.pulse = 85; l.dsu = 45; end
            default: begin l.cyc = 70; l.sel = 65; l.adv = 65; l.pulse = 55; l.dsu = 30; end
        endcase
        return l;
    endfunction

    function automatic int unsigned clk_ceil(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned sub_floor0(input int unsigned a, input int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

    function automatic phase_len_t calc_phases(input int unsigned grade, input int unsigned period);
        limits_ns_t l;
        phase_len_t p;
        l = grade_limits(grade);
        p.setup  = umax(1, clk_ceil(l.asu, period));
        p.strobe = umax(1, umax(clk_ceil(l.pulse, period), clk_ceil(l.dsu, period)));
        p.strobe = umax(p.strobe, sub_floor0(clk_ceil(l.sel, period), p.setup));
        p.strobe = umax(p.strobe, sub_floor0(clk_ceil(l.adv, period), p.setup));
        p.hold   = umax(1, umax(clk_ceil(l.rec, period), clk_ceil(l.dhd, period)));
        p.busy   = umax(p.setup + p.strobe + p.hold, clk_ceil(l.cyc, period));
        p.recover = p.busy - (p.setup + p.strobe + p.hold);
        return p;
    endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int unsigned SETUP_C   = 1,
    parameter int unsigned STROBE_C  = 3,
    parameter int unsigned HOLD_C    = 1,
    parameter int unsigned RECOVER_C = 0,
    parameter int unsigned CNT_W     = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    output phase_e phase_q,
    output phase_e phase_d,
    output logic   idle
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign idle     = (phase_q == PH_IDLE);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
        case (phase_q)
            PH_IDLE: if (accept) begin
                phase_d = PH_SETUP;
                cnt_d   = CNT_W'(SETUP_C - 1);
            end
            PH_SETUP: if (cnt_zero) begin
                phase_d = PH_STROBE;
                cnt_d   = CNT_W'(STROBE_C - 1);
            end
            PH_STROBE: if (cnt_zero) begin
                phase_d = PH_HOLD;
                cnt_d   = CNT_W'(HOLD_C - 1);
            end
            PH_HOLD: if (cnt_zero) begin
                if (RECOVER_C > 0) begin
                    phase_d = PH_RECOVER;
                    cnt_d   = CNT_W'(RECOVER_C - 1);
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            PH_RECOVER: if (cnt_zero) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STROBE && $past(phase_q) != PH_STROBE) |-> $past(phase_q) == PH_SETUP); // R4
    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && $past(phase_q) != PH_HOLD) |-> $past(phase_q) == PH_STROBE); // R6

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  phase_e            phase_d,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_we_n
);
    // Strobes are registered from the next phase so the pins come from flops
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            mem_dq_o  <= '0;
            mem_dq_oe <= 1'b0;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_data;
            end
            mem_ce_n  <= !(phase_d inside {PH_SETUP, PH_STROBE, PH_HOLD});
            mem_we_n  <= (phase_d != PH_STROBE);
            mem_dq_oe <= (phase_d inside {PH_STROBE, PH_HOLD});
        end
    end

    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n); // R6
    AST_WE_FALL_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_ce_n)); // R4
    AST_CE_OUTLASTS_WE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_ce_n); // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R3
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o)); // R5
    AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> !mem_we_n); // R5

endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CLK_NS = 20,
    parameter int unsigned GRADE  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_we_n
);
    localparam phase_len_t  LEN   = calc_phases(GRADE, CLK_NS);
    localparam int unsigned CNT_W = $clog2(LEN.busy + 1);

    phase_e phase_q, phase_d;
    logic   idle, accept;

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    sram_wr_fsm #(
        .SETUP_C   (LEN.setup),
        .STROBE_C  (LEN.strobe),
        .HOLD_C    (LEN.hold),
        .RECOVER_C (LEN.recover),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .idle    (idle)
    );

    sram_wr_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .phase_d   (phase_d),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n)
    );

    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> ($stable(mem_addr) && $stable(mem_dq_o))); // R2
    AST_READY_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n); // R7

endmodule

// File: tb/tb_sram_write_seq.sv
module tb_sram_write_seq;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int TNS = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_data  = '0;

    logic          rdy  [3];
    logic [AW-1:0] maddr[3];
    logic [DW-1:0] mdq  [3];
    logic          moe  [3];
    logic          mce  [3];
    logic          mwe  [3];

    sram_write_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(TNS), .GRADE(0)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[0]),
        .req_addr(req_addr), .req_data(req_data), .mem_addr(maddr[0]),
        .mem_dq_o(mdq[0]), .mem_dq_oe(moe[0]), .mem_ce_n(mce[0]), .mem_we_n(mwe[0]));
    sram_write_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(TNS), .GRADE(1)) dut_g1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[1]),
        .req_addr(req_addr), .req_data(req_data), .mem_addr(maddr[1]),
        .mem_dq_o(mdq[1]), .mem_dq_oe(moe[1]), .mem_ce_n(mce[1]), .mem_we_n(mwe[1]));
    sram_write_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(TNS), .GRADE(2)) dut_g2 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[2]),
        .req_addr(req_addr), .req_data(req_data), .mem_addr(maddr[2]),
        .mem_dq_o(mdq[2]), .mem_dq_oe(moe[2]), .mem_ce_n(mce[2]), .mem_we_n(mwe[2]));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input string what, input int g, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s grade%0d %s actual=%0d expected=%0d", req, g, what, act, exp);
        end
    endtask

    // Limits per grade in ns: cycle, select, pulse, data setup
    function automatic int t_wc(input int g); return (g == 0) ? 70 : (g == 1) ? 85 : 120; endfunction
    function automatic int t_cw(input int g); return (g == 0) ? 65 : (g == 1) ? 75 : 100; endfunction
    function automatic int t_wp(input int g); return (g == 0) ? 55 : (g == 1) ? 65 : 85; endfunction
    function automatic int t_dw(input int g); return (g == 0) ? 30 : (g == 1) ? 35 : 45; endfunction
    function automatic int cdiv(input int a); return (a + TNS - 1) / TNS; endfunction
    function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

    function automatic int len_s(input int g); return mx(1, cdiv(0)); endfunction
    function automatic int len_p(input int g);
        return mx(mx(1, cdiv(t_wp(g))), mx(cdiv(t_dw(g)), cdiv(t_cw(g)) - len_s(g)));
    endfunction
    function automatic int len_h(input int g); return mx(1, mx(cdiv(5), cdiv(0))); endfunction
    function automatic int len_b(input int g);
        return mx(len_s(g) + len_p(g) + len_h(g), cdiv(t_wc(g)));
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit noise);
        int we_low[3];
        int ce_low[3];
        while (!(rdy[0] && rdy[1] && rdy[2])) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        for (int g = 0; g < 3; g++) begin we_low[g] = 0; ce_low[g] = 0; end
        for (int k = 0; k < 9; k++) begin
            for (int g = 0; g < 3; g++) begin
                int s = len_s(g);
                int p = len_p(g);
                int h = len_h(g);
                chk("R3", "ce_n", g, int'(mce[g]), (k < s + p + h) ? 0 : 1);
                chk("R4", "we_n", g, int'(mwe[g]), (k >= s && k < s + p) ? 0 : 1);
                chk("R5", "dq_oe", g, int'(moe[g]), (k >= s && k < s + p + h) ? 1 : 0);
                chk("R7", "ready", g, int'(rdy[g]), (k >= len_b(g)) ? 1 : 0);
                chk("R2", "addr", g, int'(maddr[g]), int'(a));
                if (moe[g]) chk("R5", "dq_o", g, int'(mdq[g]), int'(d));
                if (!mwe[g]) we_low[g]++;
                if (!mce[g]) ce_low[g]++;
            end
            if (noise && k < 4) begin
                req_valid = 1'b1;
                req_addr  = ~a;
                req_data  = ~d;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        for (int g = 0; g < 3; g++) begin
            chk("R8", "pulse_ns_ok", g, int'(we_low[g] * TNS >= t_wp(g) && we_low[g] * TNS >= t_dw(g)), 1);
            chk("R8", "select_ns_ok", g, int'((ce_low[g] - len_h(g)) * TNS >= t_cw(g)), 1);
            chk("R6", "ce_after_we", g, ce_low[g] - we_low[g], len_s(g) + len_h(g));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int g = 0; g < 3; g++) begin
            chk("R1", "ready_rst", g, int'(rdy[g]), 1);
            chk("R1", "ce_n_rst", g, int'(mce[g]), 1);
            chk("R1", "we_n_rst", g, int'(mwe[g]), 1);
            chk("R1", "oe_rst", g, int'(moe[g]), 0);
        end
        rst = 1'b0;
        req_addr = 12'hABC;
        req_data = 8'h5A;
        repeat (3) @(negedge clk);
        for (int g = 0; g < 3; g++) begin
            chk("R2", "idle_no_valid_ce", g, int'(mce[g]), 1);
            chk("R2", "idle_no_valid_addr", g, int'(maddr[g]), 0);
        end
        for (int i = 0; i < 16; i++) begin
            logic [AW-1:0] a = AW'((i * 331 + 7) ^ (i << 8));
            logic [DW-1:0] d = DW'(i * 29 + 3);
            if (i == 14) begin a = '1; d = '1; end
            if (i == 15) begin a = '0; d = '0; end
            do_write(a, d, (i % 2) == 1);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule